// File: doc/BRIEF.md
# Hybrid Lookahead / Conditional-Sum 64-bit Adder

This block adds two 64-bit operands and a carry-in, and returns a 64-bit sum and a carry-out. The low half is built from 4-bit lookahead groups. A second lookahead level combines those groups and produces the carry into bit 32. The high half is split into 8-bit chunks. Each chunk works out two results ahead of time, one for an incoming carry of 0 and one for an incoming carry of 1. Once the real carry is known, a chunk-wide multiplexer picks the right result. Every bit forms generate, propagate and kill terms, and the chunk carry chains use these terms.

A register row sits behind the lookahead stage. It holds the low-half sum, the carry into bit 32 and both precomputed results of every upper chunk. The second stage chains the selections up through the chunks and registers the result. The adder accepts an operand set on every clock cycle and returns each result two cycles later. A valid flag travels alongside the data.

Top module: `hla_add64`

## Requirements
- R1: When out_vld is high, {out_cout, out_sum} equals the 65-bit value in_a + in_b + in_cin of the operand set that produced it. out_cout is bit 64 of that total.
- R2: An operand set sampled with in_vld high on a rising edge appears at the outputs with out_vld high right after the second rising edge that follows.
- R3: A new operand set can be presented on every cycle. Results come out in issue order and do not disturb each other.
- R4: out_vld is low whenever in_vld was low on the rising edge two edges earlier. A bubble produces no result.
- R5: Reset is synchronous and active high. Every rising edge with rst high clears both valid stages, so out_vld is low in the cycle after and operand sets already in flight are dropped. Inputs presented while rst is high produce no result.
- R6: A carry out of the low 32 bits enters bit 32. For example, 0x0000_0000_FFFF_FFFF + 1 gives 0x0000_0001_0000_0000.
- R7: A carry crosses each upper chunk boundary (bits 40, 48, 56) and leaves bit 63 as out_cout. With in_a all ones, in_b zero and in_cin 1, the sum is zero and out_cout is 1.
- R8: For every upper chunk, the result precomputed for carry-in 1 is exactly one more (as a 9-bit {carry, sum} value) than the result precomputed for carry-in 0. A chunk that generates a carry passes it on without any incoming carry. An all-propagate chunk passes a carry only when one arrives.
- R9: in_cin adds one at bit 0. For example, 0 + 0 with in_cin 1 gives a sum of 1 and out_cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_vld | input | 1 | Operand set on in_a/in_b/in_cin is valid |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_cin | input | 1 | Carry into bit 0 |
| out_vld | output | 1 | out_sum/out_cout hold a result |
| out_sum | output | 64 | Sum, modulo 2^64 |
| out_cout | output | 1 | Carry out of bit 63 |

## Verification
The bench targets carries that start in the lookahead half and have to cross bit 32. If the group carry is wrong there, the upper word comes out one too low. It also drives chains of all-propagate chunks that carry across bits 40, 48 and 56 up to out_cout. A swapped select or a broken link from one chunk to the next shows up there as a stale upper byte or a missing carry-out. Random back-to-back traffic with bubbles, plus a reset in the middle of the stream, exposes a valid pipeline that is too short, too long or not cleared. Those faults appear as results shifted by a cycle, phantom results, or results that survive a reset.

// File: rtl/hla_pkg.sv
package hla_pkg;

  // Widest generate/propagate vector a lookahead term may span.
  localparam int LA_MAX = 16;

  function automatic logic bit_gen(input logic a, input logic b);
    return a & b;
  endfunction

  function automatic logic bit_prop(input logic a, input logic b);
    return a ^ b;
  endfunction

  function automatic logic bit_kill(input logic a, input logic b);
    return ~(a | b);
  endfunction

  // Carry into position j, written in flat sum-of-products form:
  // OR over k<j of g[k] AND p[k+1..j-1], plus p[0..j-1] AND c0.
  function automatic logic la_carry(input logic [LA_MAX-1:0] g,
                                    input logic [LA_MAX-1:0] p,
                                    input logic c0, input int j);
    logic res;
    logic term;
    res = 1'b0;
    for (int k = 0; k < LA_MAX; k++) begin
      if (k < j) begin
        term = g[k];
        for (int m = 0; m < LA_MAX; m++)
          if (m > k && m < j) term = term & p[m];
        res = res | term;
      end
    end
    term = c0;
    for (int m = 0; m < LA_MAX; m++)
      if (m < j) term = term & p[m];
    return res | term;
  endfunction

endpackage

// File: rtl/hla_cla_grp.sv
module hla_cla_grp
  import hla_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          grp_g,
  output logic          grp_a
);

  logic [GW-1:0] g;
  logic [GW-1:0] p;
  logic [GW-1:0] c;

  always_comb begin
    for (int i = 0; i < GW; i++) begin
      g[i] = bit_gen(a[i], b[i]);
      p[i] = bit_prop(a[i], b[i]);
    end
    for (int i = 0; i < GW; i++)
      c[i] = la_carry(LA_MAX'(g), LA_MAX'(p), cin, i);
    sum   = p ^ c;
    grp_g = la_carry(LA_MAX'(g), LA_MAX'(p), 1'b0, GW);
    grp_a = &p;
  end

endmodule

// File: rtl/hla_low_half.sv
module hla_low_half
  import hla_pkg::*;
#(
  parameter int W  = 32,
  parameter int GW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int NG = W / GW;

  logic [NG-1:0] grp_g;
  logic [NG-1:0] grp_a;
  logic [NG:0]   grp_c;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    hla_cla_grp #(.GW(GW)) u_grp (
      .a     (a[gi*GW +: GW]),
      .b     (b[gi*GW +: GW]),
      .cin   (grp_c[gi]),
      .sum   (sum[gi*GW +: GW]),
      .grp_g (grp_g[gi]),
      .grp_a (grp_a[gi])
    );
  end

  // Second lookahead level over the group generate/propagate terms.
  always_comb begin
    for (int gi = 0; gi <= NG; gi++)
      grp_c[gi] = la_carry(LA_MAX'(grp_g), LA_MAX'(grp_a), cin, gi);
  end

  assign cout = grp_c[NG];

endmodule

// File: rtl/hla_dual_chunk.sv
module hla_dual_chunk
  import hla_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum0,
  output logic         cout0,
  output logic [W-1:0] sum1,
  output logic         cout1
);

  logic [W-1:0] g, p, k;
  logic [W:0]   c0, c1;

  always_comb begin
    c0[0] = 1'b0;
    c1[0] = 1'b1;
    for (int i = 0; i < W; i++) begin
      g[i] = bit_gen(a[i], b[i]);
      p[i] = bit_prop(a[i], b[i]);
      k[i] = bit_kill(a[i], b[i]);
      c0[i+1] = g[i] | (~k[i] & c0[i]);
      c1[i+1] = g[i] | (~k[i] & c1[i]);
    end
    sum0  = p ^ c0[W-1:0];
    sum1  = p ^ c1[W-1:0];
    cout0 = c0[W];
    cout1 = c1[W];
  end

endmodule

// File: rtl/hla_add64.sv
module hla_add64
  import hla_pkg::*;
#(
  parameter int W       = 64,
  parameter int LOW_W   = 32,
  parameter int CHUNK_W = 8,
  parameter int GRP_W   = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_cin,
  output logic         out_vld,
  output logic [W-1:0] out_sum,
  output logic         out_cout
);

  localparam int HIGH_W = W - LOW_W;
  localparam int NCH    = HIGH_W / CHUNK_W;

  // ---------------- stage 1: lookahead and precompute ----------------
  logic [LOW_W-1:0]  low_sum;
  logic              low_cout;
  logic [HIGH_W-1:0] pre_sum0, pre_sum1;
  logic [NCH-1:0]    pre_co0, pre_co1;

  hla_low_half #(.W(LOW_W), .GW(GRP_W)) u_low (
    .a    (in_a[LOW_W-1:0]),
    .b    (in_b[LOW_W-1:0]),
    .cin  (in_cin),
    .sum  (low_sum),
    .cout (low_cout)
  );

  for (genvar ci = 0; ci < NCH; ci++) begin : g_chunk
    hla_dual_chunk #(.W(CHUNK_W)) u_chunk (
      .a     (in_a[LOW_W + ci*CHUNK_W +: CHUNK_W]),
      .b     (in_b[LOW_W + ci*CHUNK_W +: CHUNK_W]),
      .sum0  (pre_sum0[ci*CHUNK_W +: CHUNK_W]),
      .cout0 (pre_co0[ci]),
      .sum1  (pre_sum1[ci*CHUNK_W +: CHUNK_W]),
      .cout1 (pre_co1[ci])
    );
  end

  logic              s1_vld;
  logic [LOW_W-1:0]  s1_low_sum;
  logic              s1_c32;
  logic [HIGH_W-1:0] s1_sum0, s1_sum1;
  logic [NCH-1:0]    s1_co0, s1_co1;

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    s1_low_sum <= low_sum;
    s1_c32     <= low_cout;
    s1_sum0    <= pre_sum0;
    s1_sum1    <= pre_sum1;
    s1_co0     <= pre_co0;
    s1_co1     <= pre_co1;
  end

  // ---------------- stage 2: chunk-wide selection ----------------
  logic [NCH:0]      sel_carry;
  logic [HIGH_W-1:0] hi_sum;

  always_comb begin
    sel_carry[0] = s1_c32;
    for (int ci = 0; ci < NCH; ci++) begin
      hi_sum[ci*CHUNK_W +: CHUNK_W] = sel_carry[ci] ? s1_sum1[ci*CHUNK_W +: CHUNK_W]
                                                    : s1_sum0[ci*CHUNK_W +: CHUNK_W];
      sel_carry[ci+1] = sel_carry[ci] ? s1_co1[ci] : s1_co0[ci];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= s1_vld;
  end

  always_ff @(posedge clk) begin
    out_sum  <= {hi_sum, s1_low_sum};
    out_cout <= sel_carry[NCH];
  end

  // ---------------- checking aids ----------------
  // Edges since reset release, saturating at 2; guards $past depth.
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                 warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  logic [W:0]     chk_in_total;
  logic [LOW_W:0] chk_low_total;
  assign chk_in_total  = {1'b0, in_a} + {1'b0, in_b} + (W+1)'(in_cin);
  assign chk_low_total = {1'b0, in_a[LOW_W-1:0]} + {1'b0, in_b[LOW_W-1:0]}
                       + (LOW_W+1)'(in_cin);

  // R1
  sum_match_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd2 && out_vld) |-> ({out_cout, out_sum} == $past(chk_in_total, 2)));

  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd2) |-> (out_vld == $past(in_vld, 2)));

  // R5
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_vld && !s1_vld));

  // R6
  low_carry_chk: assert property (@(posedge clk) disable iff (rst)
    low_cout == chk_low_total[LOW_W]);

  for (genvar ci = 0; ci < NCH; ci++) begin : g_chunk_chk
    // R8
    pair_step_chk: assert property (@(posedge clk) disable iff (rst)
      {pre_co1[ci], pre_sum1[ci*CHUNK_W +: CHUNK_W]} ==
      (CHUNK_W+1)'({pre_co0[ci], pre_sum0[ci*CHUNK_W +: CHUNK_W]} + (CHUNK_W+1)'(1)));
  end

endmodule

// File: tb/hla_add64_tb_top.sv
module hla_add64_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_vld;
  logic [63:0] in_a, in_b;
  logic        in_cin;
  logic        out_vld;
  logic [63:0] out_sum;
  logic        out_cout;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hla_add64 dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
    .in_cin(in_cin), .out_vld(out_vld), .out_sum(out_sum), .out_cout(out_cout)
  );

  // Stimulus table: operand A, operand B, carry-in, requirement tag.
  localparam int NV = 13;
  localparam logic [63:0] TA [NV] = '{
    64'h0,                   64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF,
    64'h0000_00FF_FFFF_FFFF, 64'h0000_FFFF_FFFF_FFFF, 64'h00FF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0080_0000_0000,
    64'h1234_5678_9ABC_DEF0, 64'h8000_0000_0000_0000, 64'h0,
    64'h00FF_0000_FFFF_FFFF};
  localparam logic [63:0] TB [NV] = '{
    64'h0,                   64'h1,                   64'h0,
    64'h0,                   64'h0,                   64'h0,
    64'h0,                   64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0080_0000_0000,
    64'h0FED_CBA9_8765_4321, 64'h8000_0000_0000_0000, 64'h0,
    64'h1};
  localparam logic TC [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                               1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  // R1 zero, R6 x2 (bit-32 crossing), R7 x4 (40/48/56/out), R1 all ones,
  // R8 chunk generate, R1 mixed, R7 top carry, R9 carry-in, R8 propagate chunk idle
  localparam int TT [NV] = '{1, 6, 6, 7, 7, 7, 7, 1, 8, 1, 7, 9, 8};

  // Reference: add in 16-bit pieces with an explicit running carry.
  function automatic logic [64:0] ref_add(input logic [63:0] a, input logic [63:0] b,
                                          input logic c);
    logic [64:0] r;
    logic [16:0] part;
    logic        cy;
    cy = c;
    for (int i = 0; i < 4; i++) begin
      part = {1'b0, a[i*16 +: 16]} + {1'b0, b[i*16 +: 16]} + {16'h0, cy};
      r[i*16 +: 16] = part[15:0];
      cy = part[16];
    end
    r[64] = cy;
    return r;
  endfunction

  // Two-deep model of what should emerge (oldest first).
  logic        m_v_old, m_v_new;
  logic [64:0] m_e_old, m_e_new;
  int          m_t_old, m_t_new;

  task automatic check_out();
    n_chk++;
    if (out_vld !== m_v_old) begin
      n_fail++;
      $display("FAIL R%0d: out_vld actual %0b expected %0b", m_v_old ? 2 : 4,
               out_vld, m_v_old);
    end
    if (m_v_old) begin
      n_chk++;
      if ({out_cout, out_sum} !== m_e_old) begin
        n_fail++;
        $display("FAIL R%0d: result actual %h expected %h", m_t_old,
                 {out_cout, out_sum}, m_e_old);
      end
    end
  endtask

  // One cycle: check what is due now, then drive the next input (R3 back-to-back).
  task automatic step(input logic [63:0] a, input logic [63:0] b, input logic c,
                      input logic v, input int tag, input logic r);
    @(negedge clk);
    check_out();
    rst    = r;
    in_a   = a;
    in_b   = b;
    in_cin = c;
    in_vld = v;
    if (r) begin
      m_v_old = 1'b0;
      m_v_new = 1'b0;
    end else begin
      m_v_old = m_v_new; m_e_old = m_e_new; m_t_old = m_t_new;
      m_v_new = v;       m_e_new = ref_add(a, b, c); m_t_new = tag;
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    rst = 1'b1; in_vld = 1'b1; in_a = '1; in_b = '1; in_cin = 1'b1;
    m_v_old = 1'b0; m_v_new = 1'b0; m_e_old = '0; m_e_new = '0;
    m_t_old = 0; m_t_new = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R5: reset state, inputs presented during reset leave no result
    n_chk++;
    if (out_vld !== 1'b0) begin
      n_fail++;
      $display("FAIL R5: out_vld during reset actual %0b expected 0", out_vld);
    end
    rst = 1'b0; in_vld = 1'b0;

    // Table walk, back-to-back
    for (int i = 0; i < NV; i++) step(TA[i], TB[i], TC[i], 1'b1, TT[i], 1'b0);

    // R3/R4: random stream with bubbles and long carry chains
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      int md;
      a  = {$urandom, $urandom};
      md = $urandom % 3;
      if (md == 0)      b = {$urandom, $urandom};
      else if (md == 1) b = ~a;
      else              b = ~a ^ (64'h1 << ($urandom % 64));
      step(a, b, 1'($urandom), ($urandom % 5) != 0, 3, 1'b0);
    end

    // R5: reset in the middle of a stream drops in-flight results
    step(64'h0000_0000_FFFF_FFFF, 64'h1, 1'b0, 1'b1, 5, 1'b0);
    step(64'h00FF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b1, 5, 1'b0);
    step(64'h1, 64'h1, 1'b0, 1'b1, 5, 1'b1);
    step(64'h2, 64'h2, 1'b0, 1'b1, 5, 1'b1);
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b1, 7, 1'b0);
    step(64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b0, 1'b1, 6, 1'b0);

    // R4: drain with bubbles
    for (int i = 0; i < 3; i++) step(64'h0, 64'h0, 1'b0, 1'b0, 4, 1'b0);

    finish_up();
  end

endmodule